// File: doc/BRIEF.md
# Double-Buffered FIR Control Front End

This block holds the 16-bit configuration word of a programmable FIR filter and turns it into the timing and mode signals the filter datapath consumes. A host writes words into a shadow copy at any time without disturbing the running filter. The shadow copy is promoted to the live copy when an asynchronous swap input changes level. The one exception is the first write after reset, which lands in the live copy directly.

From the live word the block produces several signals. A sample strobe runs at the system clock divided by 1, 2, 4 or 8. An output-valid strobe either follows every sample or every other sample. The block also decodes single/dual and cascade mode flags and a two-bit device-position code. Finally it drives a coefficient-bank select that can follow a pin, be pinned by a register bit, or flip on every sample. Promotion through the swap input waits for a sample-strobe boundary, so the divider and the decimation phase never see a torn word. A sticky flag reports writes that set reserved bits.

Top module: `cfg_shadow_ctrl`

## Requirements
- R1: After reset the live word is 0x0000, the reserved-bit flag is low, the bank select is 0, and the sample and output-valid strobes are high on every cycle.
- R2: Once the live word has been loaded, a host write changes only the shadow word; the live word stays unchanged until a swap event.
- R3: The first host write after reset is visible on the live word in the cycle after the write, with no swap event.
- R4: Any level change on `swap_in` is taken through a two-flop synchroniser and copies the shadow word into the live word on the next sample strobe. The live word is still unchanged two cycles after the input change.
- R5: Live bits 14:13 set the sample strobe period: 0 gives 1 cycle, 1 gives 2, 2 gives 4 and 3 gives 8, with strobes exactly that many cycles apart.
- R6: When a newly loaded word changes bits 14:13, the divider restarts, so the sample strobe is high in the first cycle the new word is live.
- R7: With live bit 12 = 1, `out_valid` is high on every second sample strobe; with bit 12 = 0, it is high on every strobe. When a load changes bit 12, the first strobe after the load carries `out_valid`.
- R8: `single_mode` equals live bit 15. `cascade_mode` is high only when bit 15 = 0 and bit 4 = 1.
- R9: `dev_pos` equals live bits 11:10 (00 intermediate, 01 interface, 10 termination, 11 single).
- R10: With live bits 7 = 0 and 5 = 0, `bank_sel` follows `bank_pin` after the two-flop synchroniser.
- R11: With live bit 7 = 1 and bit 5 = 0, `bank_sel` equals live bit 6 and ignores `bank_pin`.
- R12: With live bit 5 = 1, `bank_sel` starts at 0 when that mode is entered and inverts in the cycle after every sample strobe.
- R13: A write with any of bits 9:8 or 3:0 set raises `resv_err` from the next cycle. The flag holds until a write with those bits clear, and the word is stored unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 16 | Host control word |
| swap_in | input | 1 | Asynchronous swap request; any level change counts |
| bank_pin | input | 1 | Asynchronous external bank choice |
| active_word | output | 16 | Live control word |
| sample_en | output | 1 | Sample strobe |
| out_valid | output | 1 | Output-valid strobe after decimation |
| single_mode | output | 1 | Single-filter mode |
| cascade_mode | output | 1 | Two filters in cascade |
| dev_pos | output | 2 | Device-position code |
| bank_sel | output | 1 | Coefficient bank select |
| resv_err | output | 1 | Sticky reserved-bit write flag |

## Verification
The bench builds the block with its default two-stage synchroniser and the fixed 16-bit word. With those values, every rate and decimation pairing can be swept in one short run. Each pairing is reached through a rate change, which exposes the divider and phase restarts at the exact activation cycle. All sixteen mode and position combinations, every reserved bit one at a time, and all three bank modes are also covered.

// File: rtl/cfg_shadow_pkg.sv
package cfg_shadow_pkg;
  localparam int CW_W = 16;
  localparam int RATE_LO = 13;
  localparam int RATE_HI = 14;
  localparam int DECIM_BIT = 12;
  localparam int SINGLE_BIT = 15;
  localparam int CASC_BIT = 4;
  localparam int POS_LO = 10;
  localparam int FORCE_EN_BIT = 7;
  localparam int FORCE_VAL_BIT = 6;
  localparam int ALT_BIT = 5;
  localparam logic [CW_W-1:0] RESV_MASK = 16'h030F;

  typedef enum logic [1:0] {BANK_PIN, BANK_FORCE, BANK_ALT} bank_mode_e;

  // low-bit mask that decides which divider counts produce a strobe
  function automatic int unsigned rate_mask(input int unsigned rate);
    return (1 << rate) - 1;
  endfunction

  function automatic bank_mode_e bank_mode(input logic [CW_W-1:0] w);
    if (w[ALT_BIT]) return BANK_ALT;
    if (w[FORCE_EN_BIT]) return BANK_FORCE;
    return BANK_PIN;
  endfunction

  function automatic logic resv_hit(input logic [CW_W-1:0] w);
    return |(w & RESV_MASK);
  endfunction
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/cfg_rate_gen.sv
module cfg_rate_gen #(
  parameter int RATE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RATE_W-1:0] rate,
  input  logic              decim,
  input  logic              restart_cnt,
  input  logic              restart_ph,
  output logic              sample_en,
  output logic              out_valid
);
  import cfg_shadow_pkg::*;
  localparam int CNT_W = (1 << RATE_W) - 1;

  logic [CNT_W-1:0] cnt_q;
  logic             ph_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt_q <= '0;
    else if (restart_cnt) cnt_q <= '0;
    else                  cnt_q <= cnt_q + 1'b1;
  end

  assign sample_en = (cnt_q & CNT_W'(rate_mask(32'(rate)))) == '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          ph_q <= 1'b0;
    else if (restart_ph) ph_q <= 1'b0;
    else if (sample_en)  ph_q <= ~ph_q;
  end

  assign out_valid = sample_en & (~decim | ~ph_q);
endmodule

// File: rtl/cfg_bank_sel.sv
module cfg_bank_sel (
  input  logic                       clk,
  input  logic                       rst_n,
  input  cfg_shadow_pkg::bank_mode_e mode,
  input  logic                       force_val,
  input  logic                       pin_s,
  input  logic                       sample_en,
  input  logic                       alt_clear,
  output logic                       bank_sel
);
  import cfg_shadow_pkg::*;
  logic alt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                alt_q <= 1'b0;
    else if (alt_clear)                        alt_q <= 1'b0;
    else if (mode == BANK_ALT && sample_en)    alt_q <= ~alt_q;
  end

  always_comb begin
    case (mode)
      BANK_ALT:   bank_sel = alt_q;
      BANK_FORCE: bank_sel = force_val;
      default:    bank_sel = pin_s;
    endcase
  end
endmodule

// File: rtl/cfg_shadow_ctrl.sv
module cfg_shadow_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [15:0] wr_data,
  input  logic        swap_in,
  input  logic        bank_pin,
  output logic [15:0] active_word,
  output logic        sample_en,
  output logic        out_valid,
  output logic        single_mode,
  output logic        cascade_mode,
  output logic [1:0]  dev_pos,
  output logic        bank_sel,
  output logic        resv_err
);
  import cfg_shadow_pkg::*;

  logic [1:0]      sync_q;
  logic            swap_s, pin_s, swap_prev, swap_tgl;
  logic            act_req, armed_q, resv_q;
  logic [CW_W-1:0] pending_q, active_q, next_word;
  // named events for the checker
  logic            direct_ld, swap_ld, load_evt, restart_cnt, restart_ph, alt_clear;

  cfg_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({swap_in, bank_pin}), .q(sync_q)
  );
  assign swap_s   = sync_q[1];
  assign pin_s    = sync_q[0];
  assign swap_tgl = swap_s ^ swap_prev;

  assign direct_ld = wr_en & armed_q;
  assign swap_ld   = act_req & sample_en & ~direct_ld;
  assign load_evt  = direct_ld | swap_ld;
  assign next_word = direct_ld ? wr_data : pending_q;

  assign restart_cnt = load_evt && (next_word[RATE_HI:RATE_LO] != active_q[RATE_HI:RATE_LO]);
  assign restart_ph  = load_evt && (next_word[DECIM_BIT] != active_q[DECIM_BIT]);
  assign alt_clear   = load_evt && bank_mode(next_word) == BANK_ALT
                                && bank_mode(active_q) != BANK_ALT;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      swap_prev <= 1'b0;
      act_req   <= 1'b0;
      armed_q   <= 1'b1;
      pending_q <= '0;
      active_q  <= '0;
      resv_q    <= 1'b0;
    end else begin
      swap_prev <= swap_s;
      act_req   <= swap_tgl | (act_req & ~load_evt);
      if (wr_en) begin
        armed_q   <= 1'b0;
        pending_q <= wr_data;
        resv_q    <= resv_hit(wr_data);
      end
      if (load_evt) active_q <= next_word;
    end
  end

  cfg_rate_gen #(.RATE_W(2)) u_rate (
    .clk(clk), .rst_n(rst_n),
    .rate(active_q[RATE_HI:RATE_LO]), .decim(active_q[DECIM_BIT]),
    .restart_cnt(restart_cnt), .restart_ph(restart_ph),
    .sample_en(sample_en), .out_valid(out_valid)
  );

  cfg_bank_sel u_bank (
    .clk(clk), .rst_n(rst_n), .mode(bank_mode(active_q)),
    .force_val(active_q[FORCE_VAL_BIT]), .pin_s(pin_s),
    .sample_en(sample_en), .alt_clear(alt_clear), .bank_sel(bank_sel)
  );

  assign active_word  = active_q;
  assign single_mode  = active_q[SINGLE_BIT];
  assign cascade_mode = ~active_q[SINGLE_BIT] & active_q[CASC_BIT];
  assign dev_pos      = active_q[POS_LO+1:POS_LO];
  assign resv_err     = resv_q;
endmodule

// File: rtl/cfg_shadow_chk.sv
module cfg_shadow_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [15:0] wr_data,
  input logic [15:0] active_word,
  input logic        sample_en,
  input logic        out_valid,
  input logic        single_mode,
  input logic        cascade_mode,
  input logic        bank_sel,
  input logic        resv_err,
  input logic        load_evt,
  input logic        armed_q
);
  // R2
  live_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_evt |=> $stable(active_word));
  // R3
  direct_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q && wr_en |=> active_word == $past(wr_data));
  // R5
  full_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active_word[14:13] == 2'b00 |-> sample_en);
  // R5
  eighth_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_en && active_word[14:13] == 2'b11 && !load_evt |=> !sample_en);
  // R7
  valid_on_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> sample_en);
  // R8
  mode_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(single_mode && cascade_mode));
  // R11
  forced_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active_word[7] && !active_word[5] |-> bank_sel == active_word[6]);
  // R13
  resv_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && (|(wr_data & 16'h030F)) |=> resv_err);
endmodule

bind cfg_shadow_ctrl cfg_shadow_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .active_word(active_word), .sample_en(sample_en), .out_valid(out_valid),
  .single_mode(single_mode), .cascade_mode(cascade_mode), .bank_sel(bank_sel),
  .resv_err(resv_err), .load_evt(load_evt), .armed_q(armed_q)
);

// File: tb/tb_cfg_shadow_ctrl.sv
module tb_cfg_shadow_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic        swap_in = 1'b0;
  logic        bank_pin = 1'b0;
  logic [15:0] active_word;
  logic        sample_en, out_valid, single_mode, cascade_mode, bank_sel, resv_err;
  logic [1:0]  dev_pos;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  cfg_shadow_ctrl dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .swap_in(swap_in), .bank_pin(bank_pin), .active_word(active_word),
    .sample_en(sample_en), .out_valid(out_valid), .single_mode(single_mode),
    .cascade_mode(cascade_mode), .dev_pos(dev_pos), .bank_sel(bank_sel),
    .resv_err(resv_err)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic [15:0] w);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = w;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic flip_swap();
    @(negedge clk);
    swap_in = ~swap_in;
  endtask

  // write, flip, then stop at the first negedge where the word is live
  task automatic load_watch(input logic [15:0] w, output bit seen);
    seen = 0;
    host_write(w);
    flip_swap();
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      if (active_word == w) begin
        seen = 1;
        break;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bit seen;
    logic [15:0] w;
    logic [1:0] prev_rate;
    logic prev_dec;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(active_word == 16'h0, "R1 live word", active_word, 0);
    check(!resv_err, "R1 flag", resv_err, 0);
    check(sample_en && out_valid, "R1 strobes", {sample_en, out_valid}, 3);
    check(!bank_sel && !single_mode && !cascade_mode && dev_pos == 0, "R1 decode",
          {bank_sel, single_mode, cascade_mode, dev_pos}, 0);

    // R3 direct load of the first write
    host_write(16'h6400);
    check(active_word == 16'h6400, "R3 direct load", active_word, 16'h6400);

    // R2 later writes stay in the shadow
    host_write(16'h2800);
    repeat (15) @(negedge clk);
    check(active_word == 16'h6400, "R2 shadow only", active_word, 16'h6400);

    // R4 swap latency and activation
    flip_swap();
    @(negedge clk);
    @(negedge clk);
    check(active_word == 16'h6400, "R4 sync delay", active_word, 16'h6400);
    repeat (14) @(negedge clk);
    check(active_word == 16'h2800, "R4 activation", active_word, 16'h2800);

    // R5 R6 R7 sweep of rate and decimation
    prev_rate = 2'd1;
    prev_dec = 1'b0;
    for (int i = 0; i < 9; i++) begin
      logic [1:0] r;
      logic d;
      int ns, nv, last, gap_bad;
      r = 2'(i);
      d = (i >= 4 && i < 8);
      w = 16'(r) << 13 | 16'(d) << 12;
      load_watch(w, seen);
      check(seen, "R4 sweep load", active_word, w);
      if (r != prev_rate)
        check(sample_en, "R6 divider restart", sample_en, 1);
      if (d != prev_dec) begin
        for (int k = 0; k < 10 && !sample_en; k++) @(negedge clk);
        check(out_valid, "R7 phase restart", out_valid, 1);
      end
      ns = 0; nv = 0; last = -1; gap_bad = 0;
      for (int c = 0; c < 64; c++) begin
        @(negedge clk);
        if (sample_en) begin
          if (last >= 0 && c - last != (1 << r)) gap_bad++;
          last = c;
          ns++;
        end
        if (out_valid) nv++;
      end
      check(ns == (64 >> r), "R5 strobe count", ns, 64 >> r);
      check(gap_bad == 0, "R5 strobe spacing", gap_bad, 0);
      check(nv == (d ? (64 >> r) / 2 : (64 >> r)), "R7 valid count", nv,
            d ? (64 >> r) / 2 : (64 >> r));
      prev_rate = r;
      prev_dec = d;
    end

    // R8 R9 mode and position sweep
    for (int m = 0; m < 4; m++) begin
      for (int p = 0; p < 4; p++) begin
        w = 16'(m >> 1) << 15 | 16'(p) << 10 | 16'(m & 1) << 4;
        load_watch(w, seen);
        check(single_mode == 1'(m >> 1), "R8 single", single_mode, m >> 1);
        check(cascade_mode == (m == 1), "R8 cascade", cascade_mode, m == 1);
        check(dev_pos == 2'(p), "R9 position", dev_pos, p);
      end
    end

    // R10 pin-follow mode
    load_watch(16'h2000, seen);
    bank_pin = 1'b1;
    repeat (4) @(negedge clk);
    check(bank_sel == 1'b1, "R10 pin high", bank_sel, 1);
    bank_pin = 1'b0;
    repeat (4) @(negedge clk);
    check(bank_sel == 1'b0, "R10 pin low", bank_sel, 0);

    // R11 forced bank, pin ignored
    load_watch(16'h20C0, seen);
    for (int k = 0; k < 8; k++) begin
      bank_pin = k[0];
      repeat (3) @(negedge clk);
      check(bank_sel == 1'b1, "R11 forced upper", bank_sel, 1);
    end
    load_watch(16'h2080, seen);
    bank_pin = 1'b1;
    repeat (4) @(negedge clk);
    check(bank_sel == 1'b0, "R11 forced lower", bank_sel, 0);
    bank_pin = 1'b0;

    // R12 alternating bank
    load_watch(16'h20A0, seen);
    check(bank_sel == 1'b0, "R12 starts lower", bank_sel, 0);
    begin
      int ns, nchg;
      logic prev_b;
      ns = 0; nchg = 0;
      prev_b = bank_sel;
      for (int c = 0; c < 40; c++) begin
        if (sample_en) ns++;
        @(negedge clk);
        if (bank_sel != prev_b) nchg++;
        prev_b = bank_sel;
      end
      check(ns == nchg && ns == 20, "R12 flips per strobe", nchg, ns);
    end

    // R13 reserved bits
    for (int b = 0; b < 16; b++) begin
      if (!(b < 4 || b == 8 || b == 9)) continue;
      host_write(16'h0400 | (16'h1 << b));
      check(resv_err, "R13 flag set", resv_err, 1);
      repeat (6) @(negedge clk);
      check(resv_err, "R13 flag sticky", resv_err, 1);
      host_write(16'h0400);
      check(!resv_err, "R13 flag cleared", resv_err, 0);
    end
    load_watch(16'h0501, seen);
    check(seen && resv_err, "R13 word stored", active_word, 16'h0501);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule